// File: doc/BRIEF.md
# PLL Coefficient Calculator

This block turns a reference clock frequency (kHz) and a wanted serial bit rate (kbps) into the 16-bit coefficient word for a bridge PLL. It also returns the bit rate that those coefficients actually produce. The work runs as a sequence of steps. First a search picks the input divider, one candidate per cycle. Then a shared iterative restoring divider computes the multiplier as a rounded-up quotient. The same divider then computes the achieved rate. A set of fixed thresholds on the achieved rate selects a two-bit frequency-range code.

A request enters through a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken in the cycle where `in_valid` and `in_ready` are both high. A result leaves through a second valid/ready handshake. `out_valid` and the result fields stay constant until the consumer raises `out_ready`, so the consumer can hold off the block for as long as it needs. The block takes no new request until the pending result has been accepted.

Top module: `pll_coef_calc`

## Requirements
- R1: The divider D is the largest value, starting at 1 and stepping by one, for which the reference is at least 2000·D kHz. This gives D = max(1, min(31, floor(ref/2000))).
- R2: The divider never exceeds 31, however large the reference.
- R3: A reference input of 0 is treated as 2000 kHz, which gives D = 1.
- R4: The multiplier M is ceil(rate·D / ref), where ref is the effective reference.
- R5: If M is above 255, the multiplier field saturates to 255 and `mul_ovf` is 1. Otherwise `mul_ovf` is 0.
- R6: `rate_out` equals floor(ref·M / D), where M is the saturated multiplier.
- R7: The range code is 3 when `rate_out` ≥ 501000, 2 when it is ≥ 251000, 1 when it is ≥ 126000, and 0 otherwise.
- R8: `cfg_word` has the range code in bits [15:14], bit 13 at 0, D in bits [12:8] and M in bits [7:0].
- R9: `in_ready` and `out_valid` are never high together. While the block is busy, `in_valid` has no effect on the result in progress.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `cfg_word`, `rate_out` and `mul_ovf` hold their values. After a cycle with `out_valid` and `out_ready` both high, `in_ready` is high in the next cycle.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block is idle and takes a request |
| ref_khz | input | REF_W | Reference frequency in kHz (0 selects 2000) |
| rate_kbps | input | RATE_W | Wanted bit rate in kbps |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result |
| cfg_word | output | 16 | Coefficient word: range, divider, multiplier |
| rate_out | output | REF_W+MUL_W | Achieved bit rate in kbps |
| mul_ovf | output | 1 | The multiplier was saturated |

## Verification
The bench uses the default parameters. With 32-bit reference and rate inputs, a 5-bit divider and an 8-bit multiplier, one run can reach the divider cap with references of 62 MHz and above, a zero reference, and a multiplier that overflows past 255. The vectors also place the achieved rate exactly on a range threshold, and put references on both sides of a 2000 kHz step. Directed tests cover a producer that offers requests while the block is busy and a consumer that holds off the result for several cycles.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MULDIV,
    ST_RATEDIV,
    ST_HOLD
  } calc_state_e;

  localparam int NUM_RANGE_TH = 3;

  // Ascending thresholds on the achieved rate (kbps); code = number met
  localparam logic [31:0] RANGE_TH [NUM_RANGE_TH] = '{
    32'd126000, 32'd251000, 32'd501000
  };

endpackage

// File: rtl/pllc_divider.sv
module pllc_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q, rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial, diff;
  logic          fits;

  // Restoring step: shift in the next numerator bit, subtract if it fits
  assign trial = {rem_q, acc_q[W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc_q  <= num;
        rem_q  <= '0;
        den_q  <= den;
        cnt_q  <= CW'(W - 1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= {acc_q[W-2:0], fits};
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = acc_q;
  assign rem  = rem_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem_q < den_q)); // R4
  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R9

endmodule

// File: rtl/pllc_div_search.sv
module pllc_div_search #(
  parameter int REF_W   = 32,
  parameter int DIV_W   = 5,
  parameter int DIV_MAX = 31,
  parameter int MIN_REF = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REF_W-1:0] ref_khz,
  output logic             done,
  output logic [DIV_W-1:0] div_out
);
  localparam int THR_W = REF_W + DIV_W + 1;

  logic [REF_W-1:0] ref_q;
  logic [THR_W-1:0] thr_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, done_q, step;

  // thr_q tracks MIN_REF * (div_q + 1): next candidate's requirement
  assign step = busy_q && (div_q < DIV_W'(DIV_MAX)) &&
                ({{(THR_W-REF_W){1'b0}}, ref_q} >= thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      thr_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        ref_q  <= ref_khz;
        div_q  <= DIV_W'(1);
        thr_q  <= THR_W'(2 * MIN_REF);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (step) begin
          div_q <= div_q + 1'b1;
          thr_q <= thr_q + THR_W'(MIN_REF);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done    = done_q;
  assign div_out = div_q;

  AST_SRCH_FEASIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_q == DIV_W'(1) ||
              {{(THR_W-REF_W){1'b0}}, ref_q} >= THR_W'(MIN_REF) * THR_W'(div_q))); // R1
  AST_SRCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_q <= DIV_W'(DIV_MAX))); // R2

endmodule

// File: rtl/pllc_range_enc.sv
module pllc_range_enc #(
  parameter int W = 40
) (
  input  logic [W-1:0] rate,
  output logic [1:0]   code
);
  import pllc_pkg::*;

  logic [NUM_RANGE_TH-1:0] hit;

  for (genvar g = 0; g < NUM_RANGE_TH; g++) begin : g_th
    assign hit[g] = rate >= W'(RANGE_TH[g]);
  end

  always_comb begin
    if (hit[2])      code = 2'd3;
    else if (hit[1]) code = 2'd2;
    else if (hit[0]) code = 2'd1;
    else             code = 2'd0;
  end

endmodule

// File: rtl/pll_coef_calc.sv
module pll_coef_calc #(
  parameter int REF_W   = 32,
  parameter int RATE_W  = 32,
  parameter int DIV_W   = 5,
  parameter int MUL_W   = 8,
  parameter int DIV_MAX = 31,
  parameter int MIN_REF = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [REF_W-1:0]       ref_khz,
  input  logic [RATE_W-1:0]      rate_kbps,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2+1+DIV_W+MUL_W-1:0] cfg_word,
  output logic [REF_W+MUL_W-1:0] rate_out,
  output logic                   mul_ovf
);
  import pllc_pkg::*;

  localparam int ACH_W = REF_W + MUL_W;
  localparam int DV_W  = (RATE_W + DIV_W > ACH_W) ? RATE_W + DIV_W : ACH_W;

  calc_state_e       state_q;
  logic [REF_W-1:0]  ref_q, ref_eff;
  logic [RATE_W-1:0] rate_q;
  logic [DIV_W-1:0]  div_q, srch_div;
  logic [MUL_W-1:0]  mul_q, mul_sat;
  logic [ACH_W-1:0]  ach_q;
  logic              ovf_q, sat_hit;
  logic              srch_start, srch_done;
  logic              dv_start, dv_busy, dv_done;
  logic [DV_W-1:0]   dv_num, dv_den, dv_quo, dv_rem;
  logic [DV_W:0]     mul_ceil;
  logic [1:0]        range_code;

  assign ref_eff    = (ref_khz == '0) ? REF_W'(MIN_REF) : ref_khz;
  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_HOLD);
  assign srch_start = in_valid && in_ready;

  pllc_div_search #(
    .REF_W(REF_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .MIN_REF(MIN_REF)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .start(srch_start), .ref_khz(ref_eff),
    .done(srch_done), .div_out(srch_div)
  );

  // Rounded-up quotient, then clamp to the multiplier field
  assign mul_ceil = {1'b0, dv_quo} + (DV_W+1)'(dv_rem != '0);
  assign sat_hit  = mul_ceil > (DV_W+1)'((1 << MUL_W) - 1);
  assign mul_sat  = sat_hit ? '1 : mul_ceil[MUL_W-1:0];

  // One shared divider: first rate*D/ref, then ref*M/D
  always_comb begin
    dv_start = 1'b0;
    dv_num   = '0;
    dv_den   = '0;
    if (state_q == ST_SEARCH && srch_done) begin
      dv_start = 1'b1;
      dv_num   = DV_W'(rate_q) * DV_W'(srch_div);
      dv_den   = DV_W'(ref_q);
    end else if (state_q == ST_MULDIV && dv_done) begin
      dv_start = 1'b1;
      dv_num   = DV_W'(ref_q) * DV_W'(mul_sat);
      dv_den   = DV_W'(div_q);
    end
  end

  pllc_divider #(.W(DV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(dv_start), .num(dv_num), .den(dv_den),
    .busy(dv_busy), .done(dv_done), .quo(dv_quo), .rem(dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ref_q   <= '0;
      rate_q  <= '0;
      div_q   <= '0;
      mul_q   <= '0;
      ach_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (srch_start) begin
          ref_q   <= ref_eff;
          rate_q  <= rate_kbps;
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: if (srch_done) begin
          div_q   <= srch_div;
          state_q <= ST_MULDIV;
        end
        ST_MULDIV: if (dv_done) begin
          mul_q   <= mul_sat;
          ovf_q   <= sat_hit;
          state_q <= ST_RATEDIV;
        end
        ST_RATEDIV: if (dv_done) begin
          ach_q   <= dv_quo[ACH_W-1:0];
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pllc_range_enc #(.W(ACH_W)) u_range (.rate(ach_q), .code(range_code));

  assign cfg_word = {range_code, 1'b0, div_q, mul_q};
  assign rate_out = ach_q;
  assign mul_ovf  = ovf_q;

  AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
  AST_BUSY_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH) |-> !dv_busy); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cfg_word) &&
                                   $stable(rate_out) && $stable(mul_ovf))); // R10
  AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R10
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mul_ovf) |-> (cfg_word[MUL_W-1:0] == '1)); // R5
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cfg_word[MUL_W+DIV_W-1:MUL_W] != '0)); // R1
  AST_GAP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cfg_word[MUL_W+DIV_W]); // R8
  AST_TOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rate_out >= ACH_W'(501000)) |-> (cfg_word[MUL_W+DIV_W+2:MUL_W+DIV_W+1] == 2'd3)); // R7

endmodule

// File: tb/sim_pll_coef_calc.sv
module sim_pll_coef_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] ref_khz = '0;
  logic [31:0] rate_kbps = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] cfg_word;
  logic [39:0] rate_out;
  logic        mul_ovf;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pll_coef_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ref_khz(ref_khz), .rate_kbps(rate_kbps), .out_valid(out_valid),
    .out_ready(out_ready), .cfg_word(cfg_word), .rate_out(rate_out),
    .mul_ovf(mul_ovf)
  );

  // {reference kHz, rate kbps, expected divider}
  localparam logic [95:0] VEC [12] = '{
    {32'd26000,  32'd500000,  32'd13},
    {32'd12000,  32'd300000,  32'd6},
    {32'd19200,  32'd400000,  32'd9},
    {32'd100000, 32'd600000,  32'd31},
    {32'd0,      32'd100000,  32'd1},
    {32'd3999,   32'd130000,  32'd1},
    {32'd4000,   32'd130000,  32'd2},
    {32'd2000,   32'd1000000, 32'd1},
    {32'd1000,   32'd50000,   32'd1},
    {32'd27000,  32'd0,       32'd13},
    {32'd62000,  32'd126000,  32'd31},
    {32'd64000,  32'd250000,  32'd31}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] rf_in, input logic [63:0] rt,
                       output logic [15:0] w, output logic [63:0] ach,
                       output logic ovf, output logic [63:0] d);
    logic [63:0] rf, m;
    logic [1:0]  rc;
    rf = (rf_in == 0) ? 64'd2000 : rf_in;
    d  = rf / 2000;
    if (d < 1)  d = 1;
    if (d > 31) d = 31;
    m   = (rt * d + rf - 1) / rf;
    ovf = (m > 255);
    if (ovf) m = 255;
    ach = rf * m / d;
    rc  = (ach >= 501000) ? 2'd3 : (ach >= 251000) ? 2'd2 : (ach >= 126000) ? 2'd1 : 2'd0;
    w   = {rc, 1'b0, d[4:0], m[7:0]};
  endtask

  task automatic send(input logic [31:0] r, input logic [31:0] rt);
    @(negedge clk);
    ref_khz = r; rate_kbps = rt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    while (!out_valid) @(negedge clk);
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_result(input logic [31:0] r, input logic [31:0] rt, input logic [31:0] exp_div);
    logic [15:0] w; logic [63:0] ach, d; logic ovf;
    model(r, rt, w, ach, ovf, d);
    chk("R1/R2/R3 divider", 64'(cfg_word[12:8]), 64'(exp_div));
    chk("R1 model divider", d, 64'(exp_div));
    chk("R4 multiplier", 64'(cfg_word[7:0]), 64'(w[7:0]));
    chk("R5 overflow", 64'(mul_ovf), 64'(ovf));
    chk("R6 achieved rate", 64'(rate_out), ach);
    chk("R7 range code", 64'(cfg_word[15:14]), 64'(w[15:14]));
    chk("R8 word", 64'(cfg_word), 64'(w));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 in_ready", 64'(in_ready), 64'd1);
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready after release", 64'(in_ready), 64'd1);

    for (int i = 0; i < 12; i++) begin
      send(VEC[i][95:64], VEC[i][63:32]);
      wait_out();
      check_result(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
      accept();
    end

    // R9: offers while busy are ignored
    send(32'd26000, 32'd500000);
    chk("R9 busy blocks in_ready", 64'(in_ready), 64'd0);
    ref_khz = 32'd100000; rate_kbps = 32'd900000; in_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 still not ready", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    wait_out();
    chk("R9 exclusive ready/valid", 64'(in_ready), 64'd0);
    check_result(32'd26000, 32'd500000, 32'd13);

    // R10: back-pressure holds the result
    begin
      logic [15:0] w0; logic [39:0] a0; logic o0;
      w0 = cfg_word; a0 = rate_out; o0 = mul_ovf;
      repeat (6) @(negedge clk);
      chk("R10 out_valid held", 64'(out_valid), 64'd1);
      chk("R10 word held", 64'(cfg_word), 64'(w0));
      chk("R10 rate held", 64'(rate_out), 64'(a0));
      chk("R10 ovf held", 64'(mul_ovf), 64'(o0));
    end
    accept();
    chk("R10 ready after accept", 64'(in_ready), 64'd1);
    chk("R10 valid drops", 64'(out_valid), 64'd0);

    // R2: very large reference still caps divider at 31
    send(32'd4000000000, 32'd2000000);
    wait_out();
    check_result(32'd4000000000, 32'd2000000, 32'd31);
    accept();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule